// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block produces the write side of a circular receive buffer that lives in local memory and is cut into 256-byte pages. A byte address is formed from an 8-bit page number in the upper half and an 8-bit offset in the lower half. The host sets three page numbers that bound the ring: the first page, the page just past the last one, and a boundary page that marks data the host has not yet consumed. The host also loads the current page, which is where the next frame will go.

For each frame the block emits byte writes that begin four bytes into the current page. Those four bytes stay free for a header. The writes walk forward and wrap from the end of the ring back to its first page. When the frame completes, the block writes the header into the reserved bytes and then moves the current page on past the frame. If the frame reaches the boundary page, storing stops, an overwrite event and a missed-packet event are raised, and the frame is discarded. An aborted frame is discarded in the same way.

Top module: `rx_ring_mgr`

## Requirements
- R1: In reset and in the first cycle after it, `cur_pg` is 0x00, `mem_we` is low and neither `ovw_evt` nor `miss_evt` is high.
- R2: Data byte n of a frame (n counted from 0) is written with `mem_we` high, one cycle after it is accepted. Its address is {page, offset}, page in bits 15:8 and offset in bits 7:0. Byte 0 goes to offset 4 of the page that `cur_pg` held at `rx_sof`, and each later byte goes to the following address.
- R3: After the byte at offset 0xFF of page (`cfg_stop_pg` − 1), the next data byte goes to offset 0x00 of `cfg_start_pg`. After offset 0xFF of any other page, it goes to offset 0x00 of the next page.
- R4: After `rx_eof`, four header writes follow on consecutive cycles, at offsets 0, 1, 2 and 3 of the frame's first page. They hold, in that order: `rx_status` as sampled with `rx_eof`, the next-frame page, bits 7:0 of (byte count + 4), and bits 15:8 of (byte count + 4).
- R5: The next-frame page is the page after the one holding the frame's final byte, with R3 wrapping applied. A frame with no data bytes counts its header bytes as its contents. `cur_pg` takes the next-frame page in the cycle after the fourth header write is issued.
- R6: A data byte whose address falls in `cfg_bound_pg` is not written. In the cycle after that byte, `ovw_evt` and `miss_evt` are both high for exactly one cycle. The rest of the frame's bytes are not written, no header is written and `cur_pg` is unchanged.
- R7: `rx_abort` during a frame ends it with no header write and leaves `cur_pg` unchanged.
- R8: `cur_wr_en` loads `cur_wr_pg` into `cur_pg` only while no frame is in progress. While a frame is in progress it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_start_pg | input | 8 | First page of the ring |
| cfg_stop_pg | input | 8 | Page just beyond the ring |
| cfg_bound_pg | input | 8 | Oldest page not yet released by the host |
| cur_wr_en | input | 1 | Host load strobe for the current page |
| cur_wr_pg | input | 8 | Value loaded into the current page |
| cur_pg | output | 8 | Current page, where the next frame starts |
| rx_sof | input | 1 | Frame start pulse |
| rx_valid | input | 1 | Data byte strobe |
| rx_byte | input | 8 | Data byte |
| rx_eof | input | 1 | Good end of frame pulse |
| rx_status | input | 8 | Receive status, sampled with `rx_eof` |
| rx_abort | input | 1 | Frame abort pulse |
| mem_we | output | 1 | Buffer write strobe |
| mem_addr | output | 16 | Buffer byte address |
| mem_wdata | output | 8 | Buffer write data |
| ovw_evt | output | 1 | Overwrite event pulse |
| miss_evt | output | 1 | Missed-packet event pulse |

## Verification
The bench sends a frame that spills from the last ring page into the first. A design that wraps at the wrong page, or not at all, writes outside the ring and breaks the address stream. Another frame ends exactly on a page edge, and a zero-length frame carries a header only; both catch off-by-one errors in the next-frame page and the count, which would make the host skip or misparse a frame. Frames that run into the boundary page, including one that starts in it, must produce no stray write, no header and no change to the current page, or unread data would be destroyed. An abort and a host load in the middle of a frame must likewise leave the current page where the frame found it.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int PAGE_W    = 8;
    localparam int OFS_W     = 8;
    localparam int ADDR_W    = PAGE_W + OFS_W;
    localparam int HDR_BYTES = 4;
    localparam int CNT_W     = 16;
    localparam int STAT_W    = 8;

    typedef logic [PAGE_W-1:0] page_t;

    typedef struct packed {
        page_t              pg;
        logic [OFS_W-1:0]   ofs;
    } baddr_t;

    typedef struct packed {
        logic [STAT_W-1:0]  status;
        page_t              nxt;
        logic [CNT_W-1:0]   cnt;
    } hdr_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_HDR,
        ST_DROP
    } rx_state_e;

    function automatic page_t ring_step(page_t pg, page_t first, page_t past_end);
        page_t inc;
        inc = pg + page_t'(1);
        return (inc == past_end) ? first : inc;
    endfunction
endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr
    import rxr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  page_t  load_pg,
    input  logic   adv,
    input  page_t  first_pg,
    input  page_t  past_pg,
    output baddr_t ptr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (load) begin
            ptr.pg  <= load_pg;
            ptr.ofs <= OFS_W'(HDR_BYTES);
        end else if (adv) begin
            if (&ptr.ofs) begin
                ptr.pg  <= ring_step(ptr.pg, first_pg, past_pg);
                ptr.ofs <= '0;
            end else begin
                ptr.ofs <= ptr.ofs + OFS_W'(1);
            end
        end
    end

    // R3
    page_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && (&ptr.ofs)) |=>
            (ptr.ofs == '0) &&
            ((ptr.pg == $past(first_pg)) || (ptr.pg == $past(ptr.pg) + page_t'(1))));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !(&ptr.ofs)) |=>
            (ptr.pg == $past(ptr.pg)) && (ptr.ofs == $past(ptr.ofs) + OFS_W'(1)));
endmodule

// File: rtl/rxr_hdr.sv
module rxr_hdr
    import rxr_pkg::*;
(
    input  hdr_t        hdr,
    input  logic [1:0]  idx,
    output logic [7:0]  byte_out
);
    always_comb begin
        unique case (idx)
            2'd0:    byte_out = hdr.status;
            2'd1:    byte_out = hdr.nxt;
            2'd2:    byte_out = hdr.cnt[7:0];
            default: byte_out = hdr.cnt[15:8];
        endcase
    end
endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cfg_start_pg,
    input  logic [7:0]  cfg_stop_pg,
    input  logic [7:0]  cfg_bound_pg,
    input  logic        cur_wr_en,
    input  logic [7:0]  cur_wr_pg,
    output logic [7:0]  cur_pg,
    input  logic        rx_sof,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_eof,
    input  logic [7:0]  rx_status,
    input  logic        rx_abort,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    output logic        ovw_evt,
    output logic        miss_evt
);
    rx_state_e        state;
    page_t            cur_q;
    page_t            frm_pg;
    logic [CNT_W-1:0] len;
    hdr_t             hdr_q;
    logic [1:0]       hidx;
    baddr_t           ptr;
    baddr_t           addr_q;
    logic [7:0]       hdr_byte;
    page_t            nxt_pg;
    logic             hit_bound;
    logic             take_byte;
    logic             start_frm;

    assign start_frm = (state == ST_IDLE) && rx_sof;
    assign hit_bound = (ptr.pg == cfg_bound_pg);
    assign take_byte = (state == ST_RECV) && !rx_abort && !rx_eof && rx_valid && !hit_bound;
    assign nxt_pg    = (ptr.ofs == '0) ? ptr.pg : ring_step(ptr.pg, cfg_start_pg, cfg_stop_pg);

    rxr_ptr u_ptr (
        .clk      (clk),
        .rst      (rst),
        .load     (start_frm),
        .load_pg  (cur_q),
        .adv      (take_byte),
        .first_pg (cfg_start_pg),
        .past_pg  (cfg_stop_pg),
        .ptr      (ptr)
    );

    rxr_hdr u_hdr (
        .hdr      (hdr_q),
        .idx      (hidx),
        .byte_out (hdr_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_q     <= '0;
            frm_pg    <= '0;
            len       <= '0;
            hdr_q     <= '0;
            hidx      <= '0;
            addr_q    <= '0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            ovw_evt   <= 1'b0;
            miss_evt  <= 1'b0;
        end else begin
            mem_we   <= 1'b0;
            ovw_evt  <= 1'b0;
            miss_evt <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cur_wr_en) cur_q <= cur_wr_pg;
                    if (rx_sof) begin
                        state  <= ST_RECV;
                        len    <= '0;
                        frm_pg <= cur_q;
                    end
                end
                ST_RECV: begin
                    if (rx_abort) begin
                        state <= ST_IDLE;
                    end else if (rx_eof) begin
                        hdr_q.status <= rx_status;
                        hdr_q.nxt    <= nxt_pg;
                        hdr_q.cnt    <= len + CNT_W'(HDR_BYTES);
                        hidx         <= '0;
                        state        <= ST_HDR;
                    end else if (rx_valid) begin
                        if (hit_bound) begin
                            ovw_evt  <= 1'b1;
                            miss_evt <= 1'b1;
                            state    <= ST_DROP;
                        end else begin
                            mem_we    <= 1'b1;
                            addr_q    <= ptr;
                            mem_wdata <= rx_byte;
                            len       <= len + CNT_W'(1);
                        end
                    end
                end
                ST_HDR: begin
                    mem_we     <= 1'b1;
                    addr_q.pg  <= frm_pg;
                    addr_q.ofs <= {{(OFS_W-2){1'b0}}, hidx};
                    mem_wdata  <= hdr_byte;
                    hidx       <= hidx + 2'd1;
                    if (hidx == 2'd3) begin
                        cur_q <= hdr_q.nxt;
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    if (rx_eof || rx_abort) state <= ST_IDLE;
                end
            endcase
        end
    end

    assign cur_pg   = cur_q;
    assign mem_addr = addr_q;

    // R6
    ovw_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ovw_evt |-> miss_evt);

    // R6
    bound_nowr_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RECV) && rx_valid && !rx_eof && !rx_abort && hit_bound) |=> !mem_we);

    // R7
    cur_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_RECV) || (state == ST_DROP)) |=> $stable(cur_pg));

    // R4
    hdr_page_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HDR) |=> (mem_we && (mem_addr[15:8] == $past(frm_pg))));

    // R6
    drop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DROP) |=> !mem_we);
endmodule

// File: tb/rx_ring_mgr_test.sv
module rx_ring_mgr_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_start_pg = 8'h40;
    logic [7:0]  cfg_stop_pg  = 8'h48;
    logic [7:0]  cfg_bound_pg = 8'h44;
    logic        cur_wr_en = 1'b0;
    logic [7:0]  cur_wr_pg = 8'h00;
    logic [7:0]  cur_pg;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_status = 8'h00;
    logic        rx_abort = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        ovw_evt;
    logic        miss_evt;

    int checks = 0;
    int errors = 0;
    int ovw_cnt = 0;
    int miss_cnt = 0;
    string cur_req = "R2";
    logic [23:0] exp_q[$];

    always #10 clk = ~clk;

    rx_ring_mgr uut (
        .clk(clk), .rst(rst),
        .cfg_start_pg(cfg_start_pg), .cfg_stop_pg(cfg_stop_pg), .cfg_bound_pg(cfg_bound_pg),
        .cur_wr_en(cur_wr_en), .cur_wr_pg(cur_wr_pg), .cur_pg(cur_pg),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_eof(rx_eof), .rx_status(rx_status), .rx_abort(rx_abort),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .ovw_evt(ovw_evt), .miss_evt(miss_evt)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] step_pg(logic [7:0] pg);
        logic [7:0] n;
        n = pg + 8'd1;
        return (n == cfg_stop_pg) ? cfg_start_pg : n;
    endfunction

    // scoreboard monitor
    always @(negedge clk) begin : mon
        logic [23:0] e;
        if (!rst) begin
            if (ovw_evt) ovw_cnt++;
            if (miss_evt) miss_cnt++;
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    check({cur_req, " unexpected write"}, {8'h0, mem_addr, mem_wdata}, 32'hFFFFFFFF);
                end else begin
                    e = exp_q.pop_front();
                    check(cur_req, {8'h0, mem_addr, mem_wdata}, {8'h0, e});
                end
            end
        end
    end

    // drives one frame and queues the writes it must produce; returns expected next current page
    task automatic send_frame(input int n, input int seed, input logic [7:0] st,
                              input bit abort_it, input bit poke_host, output logic [7:0] exp_cur);
        logic [7:0] pg;
        logic [7:0] ofs;
        logic [7:0] first;
        logic [7:0] nx;
        logic [15:0] cnt;
        bit ovf;
        pg = cur_pg; ofs = 8'd4; first = cur_pg; ovf = 0;
        exp_cur = cur_pg;
        @(negedge clk) rx_sof = 1'b1;
        @(negedge clk) rx_sof = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] d;
            d = 8'((i * 7 + seed) & 8'hFF);
            if (!ovf && pg == cfg_bound_pg) ovf = 1;
            if (!ovf) begin
                exp_q.push_back({pg, ofs, d});
                if (ofs == 8'hFF) begin pg = step_pg(pg); ofs = 8'h00; end
                else ofs = ofs + 8'd1;
            end
            rx_valid = 1'b1; rx_byte = d;
            if (poke_host && i == 1) begin cur_wr_en = 1'b1; cur_wr_pg = 8'h45; end
            @(negedge clk);
            rx_valid = 1'b0; cur_wr_en = 1'b0;
        end
        if (abort_it) begin
            rx_abort = 1'b1;
            @(negedge clk) rx_abort = 1'b0;
        end else begin
            rx_eof = 1'b1; rx_status = st;
            @(negedge clk) rx_eof = 1'b0;
            if (!ovf) begin
                nx = (ofs == 8'h00) ? pg : step_pg(pg);
                cnt = 16'(n + 4);
                exp_q.push_back({first, 8'd0, st});
                exp_q.push_back({first, 8'd1, nx});
                exp_q.push_back({first, 8'd2, cnt[7:0]});
                exp_q.push_back({first, 8'd3, cnt[15:8]});
                exp_cur = nx;
            end
        end
        repeat (8) @(negedge clk);
        check({cur_req, " queue drained"}, exp_q.size(), 0);
    endtask

    initial begin : wdog
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [7:0] ec;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 cur_pg", cur_pg, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 events", {ovw_evt, miss_evt}, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after release", {mem_we, ovw_evt, cur_pg}, 0);

        // R8 host load while idle
        cur_req = "R8";
        cur_wr_en = 1'b1; cur_wr_pg = 8'h46;
        @(negedge clk) cur_wr_en = 1'b0;
        check("R8 idle load", cur_pg, 8'h46);

        // R2 R4 R5 short frame
        cur_req = "R4";
        send_frame(10, 3, 8'h21, 0, 0, ec);
        check("R5 cur after short", cur_pg, ec);
        check("R5 cur short value", cur_pg, 8'h47);

        // R3 frame wrapping from last ring page to first
        cur_req = "R3";
        send_frame(300, 11, 8'h01, 0, 0, ec);
        check("R3 cur after wrap", cur_pg, 8'h41);

        // R5 frame ending exactly at a page edge
        cur_req = "R5";
        send_frame(252, 5, 8'h03, 0, 0, ec);
        check("R5 exact page end", cur_pg, 8'h42);

        // R6 run into boundary page
        cur_req = "R6";
        send_frame(600, 9, 8'h05, 0, 0, ec);
        check("R6 cur unchanged", cur_pg, 8'h42);
        check("R6 overwrite event", ovw_cnt, 1);
        check("R6 missed event", miss_cnt, 1);

        // R7 abort
        cur_req = "R7";
        send_frame(5, 1, 8'h07, 1, 0, ec);
        check("R7 cur unchanged", cur_pg, 8'h42);

        // R8 host load during a frame is ignored
        cur_req = "R8";
        send_frame(3, 2, 8'h09, 0, 1, ec);
        check("R8 mid-frame load ignored", cur_pg, 8'h43);

        // R4 zero-length frame: header only, count 4
        cur_req = "R4";
        send_frame(0, 0, 8'h0B, 0, 0, ec);
        check("R4 zero length next page", cur_pg, 8'h44);

        // R6 frame starting in the boundary page
        cur_req = "R6";
        send_frame(2, 4, 8'h0D, 0, 0, ec);
        check("R6 start at bound cur", cur_pg, 8'h44);
        check("R6 start at bound event", ovw_cnt, 2);

        // R2 after host releases space
        cur_req = "R2";
        cfg_bound_pg = 8'h40;
        send_frame(20, 6, 8'h11, 0, 0, ec);
        check("R2 cur after release", cur_pg, 8'h45);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule